// File: doc/BRIEF.md
# Power Mode Sequencer

This block decides when a contactless reader core may run its oscillator, drive its antenna and respond to its host. It knows three ways of saving power. An active-low pin puts the whole core into a deep sleep. A bit in a control register puts it into a light sleep. Two transmitter enable bits switch the antenna drivers off.

The host reaches the block through a small register bus. That bus has an address, a write strobe, write data and a registered read port. The outputs are level controls for the rest of the core: oscillator enable, input isolation, output freeze, one enable for each antenna driver, a flag for each power mode, and a ready indication.

Leaving light sleep is not immediate. When the host clears the sleep bit, the bit keeps reading 1 while a fixed wake-up count runs on the always-running reference clock. The hardware clears the bit itself when the count ends.

Top module: `pmc_power_ctrl`

## Requirements
- R1: When `rst` is released, every register is 0. `reg_rdata_o` is 0, `osc_en_o` is 1, `in_isolate_o`, `out_freeze_o`, both driver enables, `hard_pd_o`, `sleep_pd_o` and `ready_o` are 0, and `tx_pd_o` is 1.
- R2: `pd_n_i` is sampled on every clock edge. From the cycle after an edge that sees it LOW, `hard_pd_o`, `in_isolate_o` and `out_freeze_o` are 1, and `osc_en_o`, both driver enables and `ready_o` are 0.
- R3: While deep sleep is in effect, host writes have no effect and `reg_rdata_o` holds its value, whatever the address.
- R4: On the first edge that sees `pd_n_i` HIGH again, every register already holds its default, including the sleep bit. Reads that follow return 0.
- R5: A write to address 0 with bit 4 set enters light sleep on that same edge. From the next cycle `sleep_pd_o` is 1, `osc_en_o` is 0, both drivers are off, and bit 4 of address 0 reads 1.
- R6: In light sleep, writes and reads still work, and every register keeps its value.
- R7: A write to address 0 with bit 4 clear, made during light sleep, starts a count of WAKE_CYCLES clocks. Call that write edge edge 0. `sleep_pd_o` stays 1 up to and including the cycle after edge WAKE_CYCLES-1. Bit 4 of address 0 reads 1 for the whole interval. The hardware then clears it. `osc_en_o` is 1 while the count runs.
- R8: A write of bit 4 = 1 while the count runs aborts the wake-up and returns to light sleep. A later clear restarts the count from zero.
- R9: Deep sleep takes priority over light sleep and over the wake-up count. After deep sleep the block is awake, with the sleep bit 0.
- R10: Address 1 holds the driver A enable in bit 0 and the driver B enable in bit 1. `tx_pd_o` is 1 when either bit is 0. Each driver enable follows its own bit only while the block is fully awake.
- R11: `ready_o` is 1 only when no power mode is active: not in deep sleep, not in light sleep or wake-up, and both driver enables set.
- R12: The register map is as follows.
  - Address 0: bits 3:0 are a stored command field, bit 4 is the sleep bit, and the upper bits read 0.
  - Address 1: the two driver enable bits, with the upper bits reading 0.
  - Address 2: a full-width scratch configuration register.
  - Address 3: reads 0.
  
  `reg_rdata_o` is registered. After each edge it shows the value the addressed register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Active-low deep power-down pin |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| osc_en_o | output | 1 | Oscillator enable |
| in_isolate_o | output | 1 | Isolate and clamp digital inputs |
| out_freeze_o | output | 1 | Freeze digital outputs |
| drv_a_en_o | output | 1 | Antenna driver A enable |
| drv_b_en_o | output | 1 | Antenna driver B enable |
| hard_pd_o | output | 1 | Deep power-down active |
| sleep_pd_o | output | 1 | Light sleep or wake-up count active |
| tx_pd_o | output | 1 | Transmitter power-down active |
| ready_o | output | 1 | No power mode active |

## Verification
The bench builds the block with its defaults: DATA_W = 8, ADDR_W = 2 and WAKE_CYCLES = 1024. The full-length wake-up interval is therefore walked cycle by cycle, and the readback of the sleep bit is compared on each of those cycles. The 10-bit wake counter also reaches its terminal value, both on a plain wake-up and on a wake-up restarted after an abort. A behavioural model compares every output on every clock, including the cycles where deep sleep interrupts light sleep.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } sleep_st_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_TXEN = 1;
  localparam int ADDR_SCR  = 2;
  localparam int CMD_W     = 4;
  localparam int SLEEP_BIT = 4;
  localparam int TX_W      = 2;

endpackage

// File: rtl/pmc_pin_sample.sv
module pmc_pin_sample (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_i,
  output logic hard_o
);

  logic hard_q;

  always_ff @(posedge clk) begin
    if (rst) hard_q <= 1'b0;
    else     hard_q <= ~pd_n_i;
  end

  assign hard_o = hard_q;

  p_pin_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !pd_n_i |=> hard_o);

endmodule

// File: rtl/pmc_sleep_seq.sv
module pmc_sleep_seq
  import pmc_pkg::*;
#(
  parameter int WAKE_CYCLES = 1024
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      hard_i,
  input  logic      set_i,
  input  logic      clr_i,
  output sleep_st_e state_o
);

  localparam int CNT_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

  sleep_st_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (hard_i) begin
      state_d = ST_AWAKE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_AWAKE: if (set_i) state_d = ST_SLEEP;
        ST_SLEEP: begin
          if (clr_i) begin
            state_d = ST_WAKE;
            cnt_d   = '0;
          end
        end
        ST_WAKE: begin
          if (set_i) begin
            state_d = ST_SLEEP;
            cnt_d   = '0;
          end else if (cnt_q == CNT_LAST) begin
            state_d = ST_AWAKE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_AWAKE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  p_enter_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AWAKE && !hard_i && set_i) |=> state_q == ST_SLEEP);

  p_wake_step_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE && !hard_i && !set_i && cnt_q != CNT_LAST)
      |=> (state_q == ST_WAKE && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_wake_done_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE && !hard_i && !set_i && cnt_q == CNT_LAST)
      |=> state_q == ST_AWAKE);

  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE && !hard_i && set_i) |=> (state_q == ST_SLEEP && cnt_q == '0));

  p_hard_wins_r9: assert property (@(posedge clk) disable iff (rst)
    hard_i |=> state_q == ST_AWAKE);

endmodule

// File: rtl/pmc_regfile.sv
module pmc_regfile
  import pmc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hard_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sleep_bit_i,
  output logic [TX_W-1:0]   tx_en_o,
  output logic              set_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [CMD_W-1:0]  cmd_q;
  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] scr_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              wr_ok, sel_ctrl, sel_tx, sel_scr;

  assign wr_ok    = we_i && !hard_i;
  assign sel_ctrl = addr_i == ADDR_W'(ADDR_CTRL);
  assign sel_tx   = addr_i == ADDR_W'(ADDR_TXEN);
  assign sel_scr  = addr_i == ADDR_W'(ADDR_SCR);

  assign set_o = wr_ok && sel_ctrl &&  wdata_i[SLEEP_BIT];
  assign clr_o = wr_ok && sel_ctrl && !wdata_i[SLEEP_BIT];

  always_ff @(posedge clk) begin
    if (rst || hard_i) begin
      cmd_q <= '0;
      tx_q  <= '0;
      scr_q <= '0;
    end else if (wr_ok) begin
      if (sel_ctrl) cmd_q <= wdata_i[CMD_W-1:0];
      if (sel_tx)   tx_q  <= wdata_i[TX_W-1:0];
      if (sel_scr)  scr_q <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[CMD_W-1:0] = cmd_q;
      rd_mux[SLEEP_BIT] = sleep_bit_i;
    end else if (sel_tx) begin
      rd_mux[TX_W-1:0] = tx_q;
    end else if (sel_scr) begin
      rd_mux = scr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (!hard_i) rdata_q <= rd_mux;
  end

  assign tx_en_o = tx_q;
  assign rdata_o = rdata_q;

  p_hard_clear_r4: assert property (@(posedge clk) disable iff (rst)
    hard_i |=> (cmd_q == '0 && tx_q == '0 && scr_q == '0));

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
    hard_i |=> $stable(rdata_o));

  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (!hard_i && !we_i) |=> ($stable(cmd_q) && $stable(tx_q) && $stable(scr_q)));

endmodule

// File: rtl/pmc_out_ctrl.sv
module pmc_out_ctrl
  import pmc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            hard_i,
  input  sleep_st_e       state_i,
  input  logic [TX_W-1:0] tx_en_i,
  output logic            osc_en_o,
  output logic            in_isolate_o,
  output logic            out_freeze_o,
  output logic            drv_a_en_o,
  output logic            drv_b_en_o,
  output logic            sleep_pd_o,
  output logic            tx_pd_o,
  output logic            ready_o
);

  logic awake;

  assign awake        = !hard_i && state_i == ST_AWAKE;
  assign osc_en_o     = !hard_i && state_i != ST_SLEEP;
  assign in_isolate_o = hard_i;
  assign out_freeze_o = hard_i;
  assign drv_a_en_o   = awake && tx_en_i[0];
  assign drv_b_en_o   = awake && tx_en_i[1];
  assign sleep_pd_o   = state_i != ST_AWAKE;
  assign tx_pd_o      = !(&tx_en_i);
  assign ready_o      = awake && !tx_pd_o;

  p_ready_r11: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (osc_en_o && !in_isolate_o && drv_a_en_o && drv_b_en_o && !sleep_pd_o));

  p_iso_r2: assert property (@(posedge clk) disable iff (rst)
    in_isolate_o |-> (!osc_en_o && out_freeze_o && !drv_a_en_o && !drv_b_en_o));

  p_tx_r10: assert property (@(posedge clk) disable iff (rst)
    tx_pd_o |-> !(drv_a_en_o && drv_b_en_o));

endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
  import pmc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int WAKE_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              osc_en_o,
  output logic              in_isolate_o,
  output logic              out_freeze_o,
  output logic              drv_a_en_o,
  output logic              drv_b_en_o,
  output logic              hard_pd_o,
  output logic              sleep_pd_o,
  output logic              tx_pd_o,
  output logic              ready_o
);

  logic            hard;
  logic            set_req, clr_req;
  logic [TX_W-1:0] tx_en;
  sleep_st_e       state;

  pmc_pin_sample u_pin (
    .clk    (clk),
    .rst    (rst),
    .pd_n_i (pd_n_i),
    .hard_o (hard)
  );

  pmc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .hard_i      (hard),
    .addr_i      (reg_addr_i),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .sleep_bit_i (state != ST_AWAKE),
    .tx_en_o     (tx_en),
    .set_o       (set_req),
    .clr_o       (clr_req),
    .rdata_o     (reg_rdata_o)
  );

  pmc_sleep_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .hard_i  (hard),
    .set_i   (set_req),
    .clr_i   (clr_req),
    .state_o (state)
  );

  pmc_out_ctrl u_out (
    .clk          (clk),
    .rst          (rst),
    .hard_i       (hard),
    .state_i      (state),
    .tx_en_i      (tx_en),
    .osc_en_o     (osc_en_o),
    .in_isolate_o (in_isolate_o),
    .out_freeze_o (out_freeze_o),
    .drv_a_en_o   (drv_a_en_o),
    .drv_b_en_o   (drv_b_en_o),
    .sleep_pd_o   (sleep_pd_o),
    .tx_pd_o      (tx_pd_o),
    .ready_o      (ready_o)
  );

  assign hard_pd_o = hard;

endmodule

// File: tb/pmc_power_ctrl_tb_top.sv
module pmc_power_ctrl_tb_top;

  localparam int W = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pd_n = 1'b1;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic osc_en, iso, frz, drv_a, drv_b, hard_pd, sleep_pd, tx_pd, ready;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_hard = 0, m_state = 0, m_cnt = 0;
  int m_cmd = 0, m_tx = 0, m_scr = 0, m_rdata = 0;

  always #5 clk = ~clk;

  pmc_power_ctrl dut_i (
    .clk(clk), .rst(rst), .pd_n_i(pd_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .osc_en_o(osc_en),
    .in_isolate_o(iso), .out_freeze_o(frz), .drv_a_en_o(drv_a),
    .drv_b_en_o(drv_b), .hard_pd_o(hard_pd), .sleep_pd_o(sleep_pd),
    .tx_pd_o(tx_pd), .ready_o(ready)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_cmd | ((m_state != 0) ? 16 : 0);
      1: return m_tx;
      2: return m_scr;
      default: return 0;
    endcase
  endfunction

  // Behavioural reference model, one step per clock edge
  always @(posedge clk) begin
    if (rst) begin
      m_hard = 0; m_state = 0; m_cnt = 0;
      m_cmd = 0; m_tx = 0; m_scr = 0; m_rdata = 0;
    end else begin
      int rd;
      rd = m_hard ? m_rdata : m_read(int'(addr));
      if (m_hard) begin
        m_state = 0; m_cnt = 0; m_cmd = 0; m_tx = 0; m_scr = 0;
      end else begin
        bit setr, clrr;
        setr = we && addr == 0 && wdata[4];
        clrr = we && addr == 0 && !wdata[4];
        case (m_state)
          0: if (setr) m_state = 1;
          1: if (clrr) begin m_state = 2; m_cnt = 0; end
          default: begin
            if (setr) begin m_state = 1; m_cnt = 0; end
            else if (m_cnt == W - 1) begin m_state = 0; m_cnt = 0; end
            else m_cnt++;
          end
        endcase
        if (we) begin
          if (addr == 0) m_cmd = int'(wdata[3:0]);
          if (addr == 1) m_tx = int'(wdata[1:0]);
          if (addr == 2) m_scr = int'(wdata);
        end
      end
      m_hard = pd_n ? 0 : 1;
      m_rdata = rd;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      int awake;
      awake = (m_hard == 0 && m_state == 0) ? 1 : 0;
      chk(m_hard ? "R3 rdata" : "R12 rdata", int'(rdata), m_rdata);
      chk("R2 hard_pd", int'(hard_pd), m_hard);
      chk("R2 isolate", int'(iso), m_hard);
      chk("R2 freeze", int'(frz), m_hard);
      chk("R5/R7 osc_en", int'(osc_en), (m_hard == 0 && m_state != 1) ? 1 : 0);
      chk("R7 sleep_pd", int'(sleep_pd), (m_state != 0) ? 1 : 0);
      chk("R10 drv_a", int'(drv_a), awake & (m_tx & 1));
      chk("R10 drv_b", int'(drv_b), awake & ((m_tx >> 1) & 1));
      chk("R10 tx_pd", int'(tx_pd), (m_tx != 3) ? 1 : 0);
      chk("R11 ready", int'(ready), (awake == 1 && m_tx == 3) ? 1 : 0);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    addr = 2'(a); wdata = 8'(d); we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    addr = 2'(a);
    step();
    v = int'(rdata);
  endtask

  task automatic wake_walk(bit full);
    int v;
    addr = 2'd0;
    wr(0, 8'h03);
    chk("R7 bit k=0", int'(rdata[4]), 1);
    chk("R7 sleep k=0", int'(sleep_pd), 1);
    for (int k = 1; k <= W + 2; k++) begin
      step();
      if (full) chk("R7 bit readback", int'(rdata[4]), (k <= W) ? 1 : 0);
      if (full || k == W - 1 || k == W)
        chk("R7/R8 sleep_pd", int'(sleep_pd), (k < W) ? 1 : 0);
    end
    rd(0, v);
    chk("R7 bit cleared", v, 8'h03);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, frozen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 rdata", int'(rdata), 0);
    chk("R1 osc_en", int'(osc_en), 1);
    chk("R1 tx_pd", int'(tx_pd), 1);
    chk("R1 ready", int'(ready), 0);
    chk("R1 sleep_pd", int'(sleep_pd), 0);

    // R12 register map
    wr(1, 8'hFF); rd(1, v); chk("R12 txen masked", v, 8'h03);
    wr(2, 8'hA5); rd(2, v); chk("R12 scratch", v, 8'hA5);
    wr(0, 8'hE5); rd(0, v); chk("R12 ctrl upper bits", v, 8'h05);
    wr(3, 8'h77); rd(3, v); chk("R12 addr3", v, 0);
    chk("R11 ready when awake", int'(ready), 1);

    // R10 transmitter power-down
    wr(1, 8'h01); chk("R10 only A", int'({drv_a, drv_b, tx_pd}), 3'b101);
    wr(1, 8'h02); chk("R10 only B", int'({drv_a, drv_b, tx_pd}), 3'b011);
    chk("R11 ready off with tx pd", int'(ready), 0);
    wr(1, 8'h03);

    // R5 enter light sleep
    wr(0, 8'h13);
    chk("R5 sleep_pd", int'(sleep_pd), 1);
    chk("R5 osc off", int'(osc_en), 0);
    chk("R5 drivers off", int'({drv_a, drv_b}), 0);
    // R6 retention and access in sleep
    rd(2, v); chk("R6 scratch kept", v, 8'hA5);
    wr(2, 8'h3C); rd(2, v); chk("R6 write in sleep", v, 8'h3C);
    rd(0, v); chk("R5 bit reads 1", v, 8'h13);

    // R7 full wake-up
    wake_walk(1'b1);

    // R8 abort then restart
    wr(0, 8'h13);
    wr(0, 8'h03);
    repeat (499) step();
    wr(0, 8'h13);
    repeat (5) step();
    chk("R8 back in sleep", int'({sleep_pd, osc_en}), 2'b10);
    wake_walk(1'b0);
    rd(1, v); chk("R6 txen kept", v, 3);

    // R9 / R2 / R3 / R4 deep sleep over wake-up
    wr(0, 8'h13);
    wr(0, 8'h03);
    repeat (10) step();
    addr = 2'd2;
    pd_n = 1'b0;
    step();
    frozen = int'(rdata);
    chk("R2 hard active", int'({hard_pd, iso, frz, osc_en}), 4'b1110);
    wr(2, 8'h99); addr = 2'd0; wr(1, 8'h03); step();
    chk("R3 rdata frozen", int'(rdata), frozen);
    chk("R2 ready off", int'(ready), 0);
    pd_n = 1'b1;
    step();
    step();
    chk("R9 awake after hard", int'(sleep_pd), 0);
    rd(0, v); chk("R4 ctrl default", v, 0);
    rd(1, v); chk("R4 txen default", v, 0);
    rd(2, v); chk("R4 scratch default", v, 0);
    chk("R9 osc on", int'(osc_en), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule